// File: doc/BRIEF.md
# Hamming(7,4) Single-Error-Correcting Codec

This block holds two independent streaming channels. The encode channel takes a 4-bit message and returns a 7-bit codeword that carries three even-parity check bits. The decode channel takes a received 7-bit word and computes a 3-bit syndrome from it. It repairs any single flipped bit and returns the repaired word, the recovered message, the syndrome and an error flag.

Bit positions in the codeword are numbered 1 to 7, with position p at vector bit p-1. The check bits sit at positions 1, 2 and 4, and the data bits fill positions 3, 5, 6 and 7. Because of this layout, a nonzero syndrome gives the position of the bad bit directly. That holds for data bits and for check bits alike.

Both channels use valid/ready. A word moves across an interface only in a cycle where valid and ready are both high. A stalled output keeps its data until it is taken. The parameter `OUT_REG` decides whether each channel is a purely combinational path (0) or has one register slice on its output (1, the default).

Top module: `hamming74_codec`

## Requirements
- R1: The encoder places msg[3], msg[2], msg[1] and msg[0] at positions 7, 6, 5 and 3, where position p is code bit p-1. It sets each check bit at position 1, 2 or 4 so that parity is even over all positions whose index has that bit set. For example, message 4'b1101 gives 7'b1100110.
- R2: The decoder syndrome is {check4, check2, check1}. Each bit is the even-parity failure over the positions that the matching check bit covers. A valid codeword gives 3'b000, and a word with exactly one flipped bit gives the 1-based position of that bit.
- R3: For a valid codeword with at most one bit flipped, whether a data bit or a check bit, the decoder outputs the original codeword. It also outputs its message, taken from positions 7, 6, 5 and 3.
- R4: The error flag is high exactly when the syndrome is nonzero. With a zero syndrome the word passes through unchanged.
- R5: Received 7'b1110110 gives syndrome 3'b101 and is repaired to 7'b1100110 with message 4'b1101. Received 7'b1100111 gives syndrome 3'b001 and is repaired to 7'b1100110.
- R6: With OUT_REG=1, a word accepted in one cycle appears at the output after the next clock edge. An output held while ready is low keeps both its valid and its data. The input's ready is high when the slice is empty or its output is being taken. With OUT_REG=0, the output valid follows the input valid, and the input ready follows the output ready, in the same cycle.
- R7: The two channels are independent. Back-pressure on one never stops a transfer on the other.
- R8: With OUT_REG=1, reset clears both output valids, and both input readys are then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Message offered to the encoder |
| enc_in_ready | output | 1 | Encoder can take a message |
| enc_in_msg | input | 4 | Message to encode |
| enc_out_valid | output | 1 | Codeword available |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_code | output | 7 | Codeword, bit p-1 is position p |
| dec_in_valid | input | 1 | Received word offered to the decoder |
| dec_in_ready | output | 1 | Decoder can take a word |
| dec_in_word | input | 7 | Received word |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes the decode result |
| dec_out_word | output | 7 | Repaired codeword |
| dec_out_msg | output | 4 | Recovered message |
| dec_out_syndrome | output | 3 | {check4, check2, check1} |
| dec_out_err | output | 1 | Syndrome is nonzero |

## Verification
An encode and a decode can complete in the same clock. The sweep provokes this by offering every message to the encoder while it feeds that message's codeword, with each single-bit error in turn, to the decoder in the same cycle. Both results are then judged against values that the bench computes arithmetically. A second case stalls the encoder output while the decoder keeps accepting words. It checks that the held codeword does not move and that the decoder results keep advancing.

// File: rtl/hamming74_pkg.sv
package hamming74_pkg;
  localparam int CHK_W  = 3;
  localparam int CODE_W = (1 << CHK_W) - 1;
  localparam int MSG_W  = CODE_W - CHK_W;
  localparam int DEC_W  = CODE_W + MSG_W + CHK_W + 1;

  function automatic bit is_check_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Mask of positions whose 1-based index has bit k set.
  function automatic logic [CODE_W-1:0] cover_mask(input int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (((p >> k) & 1) != 0) m = m | (CODE_W'(1) << (p - 1));
    return m;
  endfunction

  // Message bit index held at data position p (data positions ascending).
  function automatic int data_index(input int p);
    int n;
    n = 0;
    for (int q = 1; q < p; q++)
      if (!is_check_pos(q)) n++;
    return n;
  endfunction

  // Position that holds message bit j.
  function automatic int data_pos(input int j);
    int n;
    int r;
    n = 0;
    r = 1;
    for (int q = 1; q <= CODE_W; q++)
      if (!is_check_pos(q)) begin
        if (n == j) r = q;
        n++;
      end
    return r;
  endfunction

  function automatic int log2_pos(input int p);
    int k;
    k = 0;
    for (int q = 0; q < 31; q++)
      if ((1 << q) == p) k = q;
    return k;
  endfunction
endpackage

// File: rtl/hamming74_encoder.sv
module hamming74_encoder
  import hamming74_pkg::*;
(
  input  logic [MSG_W-1:0]  msg,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] placed;

  for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
    if (is_check_pos(p)) begin : g_chk
      localparam int K = log2_pos(p);
      assign placed[p-1] = 1'b0;
      assign code[p-1]   = ^(placed & cover_mask(K));
    end else begin : g_dat
      localparam int DI = data_index(p);
      assign placed[p-1] = msg[DI];
      assign code[p-1]   = placed[p-1];
    end
  end
endmodule

// File: rtl/hamming74_decoder.sv
module hamming74_decoder
  import hamming74_pkg::*;
(
  input  logic [CODE_W-1:0] word,
  output logic [CODE_W-1:0] fixed,
  output logic [MSG_W-1:0]  msg,
  output logic [CHK_W-1:0]  syn,
  output logic              err
);
  logic [CODE_W-1:0] flip;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syn[k] = ^(word & cover_mask(k));
  end

  for (genvar p = 1; p <= CODE_W; p++) begin : g_flip
    assign flip[p-1] = (syn == CHK_W'(p));
  end

  assign fixed = word ^ flip;
  assign err   = |syn;

  for (genvar j = 0; j < MSG_W; j++) begin : g_msg
    localparam int DP = data_pos(j);
    assign msg[j] = fixed[DP-1];
  end
endmodule

// File: rtl/hamming74_slice.sv
module hamming74_slice #(
  parameter int W          = 8,
  parameter int REGISTERED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REGISTERED != 0) begin : g_reg
    logic         full;
    logic [W-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full <= 1'b0;
        hold <= '0;
      end else if (in_valid && in_ready) begin
        full <= 1'b1;
        hold <= in_data;
      end else if (out_ready) begin
        full <= 1'b0;
      end
    end

    assign in_ready  = !full || out_ready;
    assign out_valid = full;
    assign out_data  = hold;
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/hamming74_codec.sv
module hamming74_codec
  import hamming74_pkg::*;
#(
  parameter int OUT_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [MSG_W-1:0]  enc_in_msg,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_word,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [CODE_W-1:0] dec_out_word,
  output logic [MSG_W-1:0]  dec_out_msg,
  output logic [CHK_W-1:0]  dec_out_syndrome,
  output logic              dec_out_err
);
  logic [CODE_W-1:0] enc_code;
  logic [CODE_W-1:0] dec_fixed;
  logic [MSG_W-1:0]  dec_msg;
  logic [CHK_W-1:0]  dec_syn;
  logic              dec_err;
  logic [DEC_W-1:0]  dec_bus;

  hamming74_encoder u_enc (
    .msg  (enc_in_msg),
    .code (enc_code)
  );

  hamming74_decoder u_dec (
    .word  (dec_in_word),
    .fixed (dec_fixed),
    .msg   (dec_msg),
    .syn   (dec_syn),
    .err   (dec_err)
  );

  hamming74_slice #(.W(CODE_W), .REGISTERED(OUT_REG)) u_enc_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_code),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_code)
  );

  hamming74_slice #(.W(DEC_W), .REGISTERED(OUT_REG)) u_dec_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   ({dec_fixed, dec_msg, dec_syn, dec_err}),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_bus)
  );

  assign {dec_out_word, dec_out_msg, dec_out_syndrome, dec_out_err} = dec_bus;
endmodule

// File: rtl/hamming74_codec_chk.sv
module hamming74_codec_chk #(
  parameter int OUT_REG = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enc_in_valid,
  input logic       enc_in_ready,
  input logic       enc_out_valid,
  input logic       enc_out_ready,
  input logic [6:0] enc_out_code,
  input logic       dec_in_valid,
  input logic       dec_in_ready,
  input logic [6:0] dec_in_word,
  input logic       dec_out_valid,
  input logic       dec_out_ready,
  input logic [6:0] dec_out_word,
  input logic [3:0] dec_out_msg,
  input logic [2:0] dec_out_syndrome,
  input logic       dec_out_err
);
  function automatic logic [2:0] parity_fail(input logic [6:0] w);
    return {w[6] ^ w[5] ^ w[4] ^ w[3],
            w[6] ^ w[5] ^ w[2] ^ w[1],
            w[6] ^ w[4] ^ w[2] ^ w[0]};
  endfunction

  assert_enc_codeword_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> parity_fail(enc_out_code) == 3'b000);

  assert_dec_repaired_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> parity_fail(dec_out_word) == 3'b000);

  assert_dec_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> dec_out_msg == {dec_out_word[6], dec_out_word[5], dec_out_word[4], dec_out_word[2]});

  if (OUT_REG != 0) begin : g_reg_checks
    assert_syndrome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid && dec_in_ready |=> dec_out_syndrome == parity_fail($past(dec_in_word)));

    assert_err_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid && dec_in_ready |=> dec_out_err == (parity_fail($past(dec_in_word)) != 3'b000));

    assert_enc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_code));

    assert_dec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_word));

    assert_enc_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid && !enc_out_ready |-> !enc_in_ready);

    assert_reset_R8: assert property (@(posedge clk)
      !rst_n |=> !enc_out_valid && !dec_out_valid);

    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid && enc_in_ready |=> enc_out_valid);
  end
endmodule

bind hamming74_codec hamming74_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .enc_in_valid     (enc_in_valid),
  .enc_in_ready     (enc_in_ready),
  .enc_out_valid    (enc_out_valid),
  .enc_out_ready    (enc_out_ready),
  .enc_out_code     (enc_out_code),
  .dec_in_valid     (dec_in_valid),
  .dec_in_ready     (dec_in_ready),
  .dec_in_word      (dec_in_word),
  .dec_out_valid    (dec_out_valid),
  .dec_out_ready    (dec_out_ready),
  .dec_out_word     (dec_out_word),
  .dec_out_msg      (dec_out_msg),
  .dec_out_syndrome (dec_out_syndrome),
  .dec_out_err      (dec_out_err)
);

// File: tb/sim_hamming74_codec.sv
`timescale 1ns/1ps
module sim_hamming74_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_in_valid = 1'b0;
  logic       enc_in_ready;
  logic [3:0] enc_in_msg = '0;
  logic       enc_out_valid;
  logic       enc_out_ready = 1'b1;
  logic [6:0] enc_out_code;
  logic       dec_in_valid = 1'b0;
  logic       dec_in_ready;
  logic [6:0] dec_in_word = '0;
  logic       dec_out_valid;
  logic       dec_out_ready = 1'b1;
  logic [6:0] dec_out_word;
  logic [3:0] dec_out_msg;
  logic [2:0] dec_out_syndrome;
  logic       dec_out_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hamming74_codec #(.OUT_REG(1)) u0 (.*);

  // Syndrome as XOR of the 1-based indices of all set bits.
  function automatic logic [2:0] idx_xor(input logic [6:0] w);
    logic [2:0] s = 3'd0;
    for (int i = 1; i <= 7; i++) if (w[i-1]) s = s ^ 3'(i);
    return s;
  endfunction

  function automatic logic [6:0] ref_enc(input logic [3:0] m);
    logic [6:0] w = '0;
    logic [2:0] s;
    w[6] = m[3]; w[5] = m[2]; w[4] = m[1]; w[2] = m[0];
    s = idx_xor(w);
    w[0] = s[0]; w[1] = s[1]; w[3] = s[2];
    return w;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic ev, input logic [3:0] m, input logic dv, input logic [6:0] w);
    @(negedge clk);
    enc_in_valid = ev; enc_in_msg = m;
    dec_in_valid = dv; dec_in_word = w;
    @(posedge clk);
    #1;
    enc_in_valid = 1'b0;
    dec_in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8", "enc_out_valid", int'(enc_out_valid), 0);
    check("R8", "dec_out_valid", int'(dec_out_valid), 0);
    check("R8", "enc_in_ready", int'(enc_in_ready), 1);
    check("R8", "dec_in_ready", int'(dec_in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R7: every message, every single error, both channels in the same cycle
    for (int m = 0; m < 16; m++) begin
      for (int e = 0; e <= 7; e++) begin
        logic [6:0] cw;
        logic [6:0] rx;
        cw = ref_enc(4'(m));
        rx = (e == 0) ? cw : (cw ^ (7'd1 << (e - 1)));
        xfer(1'b1, 4'(m), 1'b1, rx);
        check("R1", "enc_out_code", int'(enc_out_code), int'(cw));
        check("R6", "enc_out_valid", int'(enc_out_valid), 1);
        check("R2", "dec_out_syndrome", int'(dec_out_syndrome), e);
        check("R3", "dec_out_word", int'(dec_out_word), int'(cw));
        check("R3", "dec_out_msg", int'(dec_out_msg), m);
        check("R4", "dec_out_err", int'(dec_out_err), (e != 0) ? 1 : 0);
        check("R7", "dec_out_valid", int'(dec_out_valid), 1);
      end
    end

    // R5: worked examples
    xfer(1'b1, 4'b1101, 1'b1, 7'b1110110);
    check("R5", "encode 1101", int'(enc_out_code), int'(7'b1100110));
    check("R5", "syndrome 101", int'(dec_out_syndrome), int'(3'b101));
    check("R5", "repair pos5", int'(dec_out_word), int'(7'b1100110));
    check("R5", "msg 1101", int'(dec_out_msg), int'(4'b1101));
    xfer(1'b0, 4'b0, 1'b1, 7'b1100111);
    check("R5", "syndrome 001", int'(dec_out_syndrome), int'(3'b001));
    check("R5", "repair pos1", int'(dec_out_word), int'(7'b1100110));
    check("R6", "enc drained", int'(enc_out_valid), 0);

    // R6 R7: stall encoder output, decoder keeps flowing
    xfer(1'b0, 4'b0, 1'b0, 7'b0);
    check("R6", "dec drained", int'(dec_out_valid), 0);
    @(negedge clk);
    enc_out_ready = 1'b0;
    xfer(1'b1, 4'hA, 1'b1, ref_enc(4'h3) ^ 7'b0001000);
    check("R6", "enc held valid", int'(enc_out_valid), 1);
    check("R6", "enc_in_ready low", int'(enc_in_ready), 0);
    check("R3", "dec word during stall", int'(dec_out_word), int'(ref_enc(4'h3)));
    xfer(1'b1, 4'h5, 1'b1, ref_enc(4'hC) ^ 7'b0100000);
    check("R6", "enc code stable", int'(enc_out_code), int'(ref_enc(4'hA)));
    check("R7", "dec advanced msg", int'(dec_out_msg), 12);
    check("R7", "dec advanced syn", int'(dec_out_syndrome), 6);
    check("R7", "dec_in_ready", int'(dec_in_ready), 1);
    @(negedge clk);
    enc_out_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R6", "enc released", int'(enc_out_valid), 0);
    check("R6", "enc_in_ready back", int'(enc_in_ready), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule